// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two tri-state buses, A and B, and moves data across them in either direction. Each direction has its own storage register. A select per direction picks what that direction drives: the live value of the opposite bus, or the value held in its register. The datapath is built from identical channels, two channels of eight bits by default. Each channel has its own six controls: an enable per direction, a capture input per direction and a stored/live select per direction. When a system drives the same level onto both channels' controls, the two channels act as one sixteen-bit unit.

Everything is timed by one system clock. The capture inputs are level signals that the block watches. A low-to-high change seen at a clock edge loads the register in that direction. The live path is retimed through one register stage, so a live transfer appears on the far bus one system clock after the source bus value is sampled. With this stage, enabling both directions together gives a sequential loop and not a combinational one. In that state the two buses keep their last value after every outside driver lets go.

Top module: `regbus_xcvr`

## Requirements
- R1: Channel c uses bus bits [8c+7:8c] and only its own control bits at index c. Any activity on one channel leaves the other channel's bus values and registers unchanged.
- R2: When a channel's A-to-B enable is 1, the block drives that channel's slice of bus B. When it is 0, the block leaves that slice undriven, so an outside driver's value reads back unchanged.
- R3: When a channel's B-to-A enable is 0, the block drives that channel's slice of bus A. When it is 1, the block leaves that slice undriven.
- R4: When a direction's select is 0 and its enable is active, the driven bus shows the opposite bus value that was sampled at the previous system clock edge.
- R5: When a direction's select is 1 and its enable is active, the driven bus shows the content of that direction's storage register. The A-to-B register feeds bus B and the B-to-A register feeds bus A.
- R6: A direction's register loads the value of its source bus at the first clock edge where its capture input is 1, after having been 0 at the previous edge. The select and enable levels do not affect this. Holding the capture input high causes no further load, and the register keeps its value between loads.
- R7: With the A-to-B enable at 0 and the B-to-A enable at 1, neither bus is driven by the block, and both registers still load from their buses.
- R8: With both selects at 0 and both enables active, and no outside drivers, each bus keeps its value on every later cycle as long as the two bus values are equal.
- R9: With both selects at 1 and both enables active, bus B shows the A-to-B register and bus A shows the B-to-A register in the same cycle.
- R10: A capture input that is already high when reset is released causes no load until it has gone low and then high again. The storage registers are not cleared by reset.
- R11: When both selects are 1 and both enables are active, a load of the A-to-B register takes in the B-to-A register's content from bus A. Loading both registers therefore needs two separate capture edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the capture edge detectors |
| abEnable | input | 2 | Per channel: 1 lets the block drive bus B |
| baEnableN | input | 2 | Per channel: 0 lets the block drive bus A |
| abCapture | input | 2 | Per channel: a rise loads the A-to-B register from bus A |
| baCapture | input | 2 | Per channel: a rise loads the B-to-A register from bus B |
| abSelStored | input | 2 | Per channel: 1 drives bus B from the register, 0 from live bus A |
| baSelStored | input | 2 | Per channel: 1 drives bus A from the register, 0 from live bus B |
| busA | inout | 16 | Bus A, tri-state |
| busB | inout | 16 | Bus B, tri-state |

## Verification
The assertions check on every cycle that the capture detectors make exactly one load pulse per rise and none while a level is held or right after reset. They also check that a register changes only on a load pulse and then takes the source bus value, and that a live output lags its source by one clock. Some behaviour only the bench's scenarios can show. These are the tri-state behaviour of the enables seen from outside, the latching loop with both directions live, the swap through a register when both selects are stored, the non-clearing reset, and the independence of the two channels. The bench shows these by comparing every bus slice to its own model on every cycle.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Per-channel strobes passed from control to datapath
  typedef struct packed {
    logic abLoad;      // load A-to-B register from bus A
    logic baLoad;      // load B-to-A register from bus B
    logic driveB;      // block drives bus B
    logic driveA;      // block drives bus A
    logic bFromStore;  // bus B value comes from the A-to-B register
    logic aFromStore;  // bus A value comes from the B-to-A register
  } chanStrobe_t;

endpackage

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abEnable,
  input  logic        baEnableN,
  input  logic        abCapture,
  input  logic        baCapture,
  input  logic        abSelStored,
  input  logic        baSelStored,
  output chanStrobe_t strobe
);

  logic abCapQ;
  logic baCapQ;

  // Previous capture levels; reset high so a level held through reset is not a rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abCapQ <= 1'b1;
      baCapQ <= 1'b1;
    end else begin
      abCapQ <= abCapture;
      baCapQ <= baCapture;
    end
  end

  always_comb begin
    strobe.abLoad     = abCapture & ~abCapQ;
    strobe.baLoad     = baCapture & ~baCapQ;
    strobe.driveB     = abEnable;
    strobe.driveA     = ~baEnableN;
    strobe.bFromStore = abSelStored;
    strobe.aFromStore = baSelStored;
  end

  // R6: one load pulse per rise of a capture input
  assert_single_load_ab_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abLoad |=> !strobe.abLoad);
  assert_single_load_ba_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.baLoad |=> !strobe.baLoad);

  // R6: a rise seen out of reset always produces a load
  assert_rise_loads_ab_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(abCapture) && $past(rstN)) |-> strobe.abLoad);
  assert_rise_loads_ba_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(baCapture) && $past(rstN)) |-> strobe.baLoad);

  // R10: a level held high across two edges never loads, including right after reset
  assert_level_no_load_ab_R10: assert property (@(posedge clk) disable iff (!rstN)
    (abCapture && $past(abCapture)) |-> !strobe.abLoad);
  assert_level_no_load_ba_R10: assert property (@(posedge clk) disable iff (!rstN)
    (baCapture && $past(baCapture)) |-> !strobe.baLoad);

endmodule

// File: rtl/regbus_path.sv
module regbus_path
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanStrobe_t   strobe,
  input  logic [W-1:0]  aIn,
  input  logic [W-1:0]  bIn,
  output logic [W-1:0]  aOut,
  output logic [W-1:0]  bOut,
  output logic          aOe,
  output logic          bOe
);

  logic [W-1:0] abStore;
  logic [W-1:0] baStore;
  logic [W-1:0] aLive;
  logic [W-1:0] bLive;

  // Storage and live sample registers: no reset by intent
  always_ff @(posedge clk) begin
    aLive <= aIn;
    bLive <= bIn;
    if (strobe.abLoad) abStore <= aIn;
    if (strobe.baLoad) baStore <= bIn;
  end

  always_comb begin
    bOut = strobe.bFromStore ? abStore : aLive;
    aOut = strobe.aFromStore ? baStore : bLive;
    bOe  = strobe.driveB;
    aOe  = strobe.driveA;
  end

  // R6: registers hold between loads
  assert_store_hold_ab_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.abLoad |=> $stable(abStore));
  assert_store_hold_ba_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.baLoad |=> $stable(baStore));

  // R6: a load takes the source bus value seen at that edge
  assert_store_take_ab_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abLoad |=> (abStore == $past(aIn)));
  assert_store_take_ba_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.baLoad |=> (baStore == $past(bIn)));

  // R4: live outputs lag their source bus by one clock
  assert_live_lag_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bOe && !strobe.bFromStore) |-> (bOut == $past(aIn)));
  assert_live_lag_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (aOe && !strobe.aFromStore) |-> (aOut == $past(bIn)));

  // R5: after a load, the stored path shows the loaded value
  assert_stored_shows_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bFromStore && $past(strobe.abLoad)) |-> (bOut == $past(aIn)));
  assert_stored_shows_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.aFromStore && $past(strobe.baLoad)) |-> (aOut == $past(bIn)));

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int CH_W   = 8,
  localparam int BUS_W  = NUM_CH * CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] abEnable,
  input  logic [NUM_CH-1:0] baEnableN,
  input  logic [NUM_CH-1:0] abCapture,
  input  logic [NUM_CH-1:0] baCapture,
  input  logic [NUM_CH-1:0] abSelStored,
  input  logic [NUM_CH-1:0] baSelStored,
  inout  wire  [BUS_W-1:0]  busA,
  inout  wire  [BUS_W-1:0]  busB
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam int LO = ch * CH_W;

    chanStrobe_t     strobe;
    logic [CH_W-1:0] aOut;
    logic [CH_W-1:0] bOut;
    logic            aOe;
    logic            bOe;

    regbus_ctrl ctrl_i (
      .clk         (clk),
      .rstN        (rstN),
      .abEnable    (abEnable[ch]),
      .baEnableN   (baEnableN[ch]),
      .abCapture   (abCapture[ch]),
      .baCapture   (baCapture[ch]),
      .abSelStored (abSelStored[ch]),
      .baSelStored (baSelStored[ch]),
      .strobe      (strobe)
    );

    regbus_path #(.W(CH_W)) path_i (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .aIn    (busA[LO +: CH_W]),
      .bIn    (busB[LO +: CH_W]),
      .aOut   (aOut),
      .bOut   (bOut),
      .aOe    (aOe),
      .bOe    (bOe)
    );

    assign busA[LO +: CH_W] = aOe ? aOut : {CH_W{1'bz}};
    assign busB[LO +: CH_W] = bOe ? bOut : {CH_W{1'bz}};
  end

endmodule

// File: tb/regbus_xcvr_tb_top.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;
  localparam int NC = 2;
  localparam int CW = 8;
  localparam int BW = NC * CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0] abEn, baEnN, abCap, baCap, abSel, baSel;
  logic [NC-1:0] extAEn, extBEn;
  logic [BW-1:0] extA, extB;
  wire  [BW-1:0] busA, busB;

  for (genvar c = 0; c < NC; c++) begin : g_ext
    assign busA[c*CW +: CW] = extAEn[c] ? extA[c*CW +: CW] : {CW{1'bz}};
    assign busB[c*CW +: CW] = extBEn[c] ? extB[c*CW +: CW] : {CW{1'bz}};
  end

  regbus_xcvr dut_i (
    .clk (clk), .rstN (rstN),
    .abEnable (abEn), .baEnableN (baEnN),
    .abCapture (abCap), .baCapture (baCap),
    .abSelStored (abSel), .baSelStored (baSel),
    .busA (busA), .busB (busB)
  );

  // Behavioural reference state per channel
  logic [CW-1:0] mRegA [NC];
  logic [CW-1:0] mRegB [NC];
  logic [CW-1:0] mLiveA [NC];
  logic [CW-1:0] mLiveB [NC];
  bit kRegA [NC], kRegB [NC], kLiveA [NC], kLiveB [NC];
  bit mPrevAB [NC], mPrevBA [NC];

  int total = 0;
  int bad = 0;
  string req = "R2 R3";
  bit finished = 0;

  task automatic check(input string what, input int c,
                       input logic [CW-1:0] got, input logic [CW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s ch%0d %s got=%h exp=%h", req, c, what, got, exp);
    end
  endtask

  // One clock: compare buses before the edge, then advance the model at the edge
  task automatic cycle();
    logic [CW-1:0] eA [NC];
    logic [CW-1:0] eB [NC];
    bit kA [NC];
    bit kB [NC];
    #1;
    for (int c = 0; c < NC; c++) begin
      kA[c] = 0; kB[c] = 0; eA[c] = '0; eB[c] = '0;
      if (extAEn[c] && !baEnN[c]) begin
        total++; bad++;
        $display("FAIL %s ch%0d busA contention got=driven exp=single", req, c);
      end else if (extAEn[c]) begin
        eA[c] = extA[c*CW +: CW]; kA[c] = 1;
      end else if (!baEnN[c]) begin
        eA[c] = baSel[c] ? mRegB[c] : mLiveB[c];
        kA[c] = baSel[c] ? kRegB[c] : kLiveB[c];
      end
      if (extBEn[c] && abEn[c]) begin
        total++; bad++;
        $display("FAIL %s ch%0d busB contention got=driven exp=single", req, c);
      end else if (extBEn[c]) begin
        eB[c] = extB[c*CW +: CW]; kB[c] = 1;
      end else if (abEn[c]) begin
        eB[c] = abSel[c] ? mRegA[c] : mLiveA[c];
        kB[c] = abSel[c] ? kRegA[c] : kLiveA[c];
      end
      if (kA[c]) check("busA", c, busA[c*CW +: CW], eA[c]);
      if (kB[c]) check("busB", c, busB[c*CW +: CW], eB[c]);
    end
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      if (!rstN) begin
        mPrevAB[c] = 1; mPrevBA[c] = 1;
      end else begin
        if (abCap[c] && !mPrevAB[c]) begin mRegA[c] = eA[c]; kRegA[c] = kA[c]; end
        if (baCap[c] && !mPrevBA[c]) begin mRegB[c] = eB[c]; kRegB[c] = kB[c]; end
        mPrevAB[c] = abCap[c]; mPrevBA[c] = baCap[c];
      end
      mLiveA[c] = eA[c]; kLiveA[c] = kA[c];
      mLiveB[c] = eB[c]; kLiveB[c] = kB[c];
    end
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      kRegA[c] = 0; kRegB[c] = 0; kLiveA[c] = 0; kLiveB[c] = 0;
      mPrevAB[c] = 1; mPrevBA[c] = 1;
    end
    abEn = '0; baEnN = '1; abCap = '0; baCap = '0; abSel = '0; baSel = '0;
    // Reset state: block idle, outside values read back untouched (R2 R3)
    extAEn = '1; extBEn = '1; extA = 16'h6996; extB = 16'hC33C;
    req = "R2 R3";
    cycles(3);
    rstN = 1'b1;
    cycles(1);

    // Isolation with loads on separate channels (R7 R1 R6)
    req = "R7 R1";
    extA = 16'h3CA5; abCap = 2'b01; cycle(); abCap = '0; cycle();
    abCap = 2'b10; cycle(); abCap = '0; cycle();
    extB = 16'hE10F; baCap = 2'b11; cycle(); baCap = '0; cycle();

    // Stored paths, opposite directions on the two channels (R5 R1)
    req = "R5 R1";
    extA = 16'h00FF; extB = 16'h8100;
    extAEn = 2'b01; extBEn = 2'b10;
    abEn = 2'b01; abSel = 2'b01; baEnN = 2'b01; baSel = 2'b10;
    cycles(3);

    // Live paths with changing sources (R4)
    req = "R4";
    abSel = '0; baSel = '0;
    for (int i = 0; i < 6; i++) begin
      extA[7:0] = 8'(i * 37 + 5);
      extB[15:8] = 8'(i * 53 + 9);
      cycle();
    end
    cycles(1);

    // Load while driving stored data; held capture loads once (R6)
    req = "R6";
    abSel = 2'b01; baSel = 2'b10;
    extA[7:0] = 8'h5B; extB[15:8] = 8'hC7; abCap = 2'b01; baCap = 2'b10; cycle();
    extA[7:0] = 8'h77; extB[15:8] = 8'h22; cycles(2);
    abCap = '0; baCap = '0; cycles(2);

    // Both directions stored and enabled, no outside drivers (R9)
    req = "R9";
    extAEn = '0; extBEn = '0;
    abEn = '1; baEnN = '0; abSel = '1; baSel = '1;
    cycles(3);

    // Loads through the other register, staggered (R11)
    req = "R11";
    abCap = '1; cycle(); abCap = '0; cycles(2);
    baCap = '1; cycle(); baCap = '0; cycles(2);

    // Live loop with equal values holds (R8)
    req = "R8";
    abSel = '0; baSel = '0;
    cycles(8);

    // Capture held high through reset does not load; registers kept (R10)
    req = "R10";
    abEn = '0; baEnN = '1; abSel = '0; baSel = '0;
    abCap = '1; rstN = 1'b0; cycles(2);
    rstN = 1'b1;
    extAEn = '1; extA = 16'h0000; cycles(3);
    abEn = '1; abSel = '1; cycles(2);
    abCap = '0; cycle(); abCap = '1; cycle(); abCap = '0; cycles(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule